// File: doc/BRIEF.md
# Privileged Call Dispatch Unit

This unit services a privileged-call instruction after decode has picked it out. Each call presents an 8-bit call code and the program counter of the calling instruction. The unit reduces the code to a slot in one of two vector ranges and adds 64 bytes per slot to a programmable vector base register. The sum becomes the next program counter. The unit also saves a return address with the caller's mode packed into bit 0.

A call made from normal mode switches the unit into privileged mode. It also raises a one-cycle request to swap in the shadow register bank. A call made from privileged mode does neither.

The unit has two more operations. A return-from-privileged operation takes a saved address and strips bit 0 to form the resume PC. The stripped bit becomes the new mode. A write to the vector base register raises a one-cycle flush pulse, because any cached call targets are then stale.

The mode is held by a two-state machine with the states MODE_NORMAL and MODE_PRIV. It has these transitions:
- MODE_NORMAL goes to MODE_PRIV on a call.
- MODE_PRIV stays in MODE_PRIV on a call.
- Either state goes to MODE_NORMAL on a return whose bit 0 is 0.
- Either state goes to MODE_PRIV on a return whose bit 0 is 1.
- Either state stays put when there is no strobe.

Every transition that changes the state raises the swap request. All outputs are registered and appear one clock after the strobe.

Top module: `priv_call_unit`

## Requirements
- R1: Code class and masking. A call code with bit 7 = 1 is in the unprivileged class and is masked with 0xBF. A call code with bit 7 = 0 is in the privileged class and is masked with 0x3F. So bit 6 of the code never affects the vector.
- R2: When the masked code has bit 7 set, the entry offset is 0x2000 + (masked − 0x80) × 64.
- R3: When the masked code has bit 7 clear, the entry offset is 0x1000 + masked × 64.
- R4: One cycle after `call_req`, `next_pc` equals the vector base plus the entry offset, modulo 2^ADDR_W. `pc_valid` is high in that cycle.
- R5: One cycle after `call_req`, `exc_addr` equals `call_pc` ORed with the pre-call mode (1 = privileged) in bit 0.
- R6: A call from normal mode sets `priv_mode` to 1 and pulses `swap_req`. A call from privileged mode leaves `priv_mode` at 1 and does not pulse `swap_req`.
- R7: A base write loads `base_wdata` and pulses `flush` one cycle later. A call in the same cycle as a base write uses the previous base. Later calls use the new base.
- R8: One cycle after a return (`ret_req` without `call_req`), three things hold:
  - `next_pc` equals `ret_addr` with bit 0 cleared.
  - `priv_mode` equals `ret_addr[0]`.
  - `pc_valid` is high and `exc_addr` is unchanged.
- R9: A return pulses `swap_req` exactly when it changes the mode, in either direction.
- R10: When `call_req` and `ret_req` are high together, the call is performed and the return is ignored.
- R11: After reset, the base is 0, `priv_mode` is 1, `next_pc` and `exc_addr` are 0, and `swap_req`, `flush` and `pc_valid` are 0.
- R12: `swap_req`, `flush` and `pc_valid` are single-cycle pulses. In a cycle after no strobe, `next_pc`, `exc_addr` and `priv_mode` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | One-cycle privileged-call strobe |
| call_code | input | 8 | Call code |
| call_pc | input | ADDR_W | PC to save as return address |
| ret_req | input | 1 | One-cycle return-from-privileged strobe |
| ret_addr | input | ADDR_W | Saved address to return to; bit 0 carries the target mode |
| base_we | input | 1 | One-cycle vector base write strobe |
| base_wdata | input | ADDR_W | New vector base value |
| next_pc | output | ADDR_W | Redirect target PC |
| pc_valid | output | 1 | Pulse: `next_pc` was updated |
| exc_addr | output | ADDR_W | Saved return address with mode in bit 0 |
| priv_mode | output | 1 | 1 = privileged mode |
| swap_req | output | 1 | Pulse: swap shadow register bank |
| flush | output | 1 | Pulse: vector base changed |

## Verification
The bench sweeps all 256 call codes twice, once from each mode, under a series of vector bases. The last base sits just below the top of the address space, so the sum wraps. A wrong mask, such as not clearing bit 6, would place codes 0x40–0x7F and 0xC0–0xFF on wrong slots. A swapped range base would send whole halves of the code space 0x1000 bytes off.

Before each call, a return sets the mode. This checks that the swap request follows mode changes in both directions. A unit that swapped on every call would double-swap privileged callers, and the bench catches this.

Two collision cases are driven on purpose:
- A base write in the same cycle as a call. A design that forwarded the new base would jump wrong.
- A call and a return in the same cycle. A design that let the return win would resume in normal mode.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int CODE_W     = 8;
    localparam int OFS_W      = 14;
    localparam int SLOT_SHIFT = 6;
    localparam int SLOT_W     = 6;

    localparam logic [OFS_W-1:0]  LOW_VEC_BASE  = 14'h1000;
    localparam logic [OFS_W-1:0]  HIGH_VEC_BASE = 14'h2000;
    localparam logic [CODE_W-1:0] USER_MASK     = 8'hBF;
    localparam logic [CODE_W-1:0] PRIV_MASK     = 8'h3F;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_PRIV   = 1'b1
    } pcu_mode_e;
endpackage

// File: rtl/pcu_vector.sv
module pcu_vector
    import pcu_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [OFS_W-1:0]  entry_ofs
);
    logic [CODE_W-1:0] masked;
    logic [SLOT_W-1:0] slot;
    logic [OFS_W-1:0]  slot_ofs;
    logic [OFS_W-1:0]  range_base;

    always_comb begin
        // Code class is chosen by bit 7; each class has its own mask.
        masked     = code[CODE_W-1] ? (code & USER_MASK) : (code & PRIV_MASK);
        slot       = masked[SLOT_W-1:0];
        slot_ofs   = OFS_W'(slot) << SLOT_SHIFT;
        range_base = masked[CODE_W-1] ? HIGH_VEC_BASE : LOW_VEC_BASE;
        entry_ofs  = range_base + slot_ofs;
    end
endmodule

// File: rtl/pcu_base_reg.sv
module pcu_base_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base_q,
    output logic              flush_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            flush_q <= 1'b0;
        end else begin
            if (wr_en) begin
                base_q <= wr_data;
            end
            flush_q <= wr_en;
        end
    end

    // R7
    base_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |-> (base_q == $past(wr_data)));

    // R12
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !flush_q);
endmodule

// File: rtl/pcu_mode_fsm.sv
module pcu_mode_fsm
    import pcu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic call_req,
    input  logic ret_req,
    input  logic ret_mode,
    output logic mode_o,
    output logic swap_q
);
    pcu_mode_e state_q;
    pcu_mode_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_PRIV;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: call has priority over return
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: begin
                if (call_req) begin
                    state_d = MODE_PRIV;
                end else if (ret_req) begin
                    state_d = ret_mode ? MODE_PRIV : MODE_NORMAL;
                end
            end
            MODE_PRIV: begin
                if (call_req) begin
                    state_d = MODE_PRIV;
                end else if (ret_req) begin
                    state_d = ret_mode ? MODE_PRIV : MODE_NORMAL;
                end
            end
            default: state_d = MODE_PRIV;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_q <= 1'b0;
        end else begin
            swap_q <= (state_d != state_q);
        end
    end

    assign mode_o = (state_q == MODE_PRIV);

    // R6
    normal_call_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !mode_o) |=> (mode_o && swap_q));

    // R6
    priv_call_noswap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && mode_o) |=> (mode_o && !swap_q));

    // R8
    ret_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req) |=> (mode_o == $past(ret_mode)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_req && !ret_req) |=> ($stable(mode_o) && !swap_q));
endmodule

// File: rtl/pcu_pc_path.sv
module pcu_pc_path
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] call_pc,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [OFS_W-1:0]  entry_ofs,
    input  logic              mode_now,
    output logic [ADDR_W-1:0] next_pc_q,
    output logic [ADDR_W-1:0] exc_addr_q,
    output logic              valid_q
);
    localparam logic [ADDR_W-1:0] MODE_BIT = ADDR_W'(1);

    logic [ADDR_W-1:0] call_target;
    logic [ADDR_W-1:0] saved_ret;
    logic [ADDR_W-1:0] resume_pc;

    always_comb begin
        call_target = base_q + ADDR_W'(entry_ofs);
        saved_ret   = call_pc | (mode_now ? MODE_BIT : '0);
        resume_pc   = ret_addr & ~MODE_BIT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_q  <= '0;
            exc_addr_q <= '0;
            valid_q    <= 1'b0;
        end else begin
            valid_q <= call_req | ret_req;
            if (call_req) begin
                next_pc_q  <= call_target;
                exc_addr_q <= saved_ret;
            end else if (ret_req) begin
                next_pc_q  <= resume_pc;
            end
        end
    end

    // R5
    exc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> (exc_addr_q[0] == ($past(call_pc[0]) | $past(mode_now))));

    // R8
    ret_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req) |=> (!next_pc_q[0] && $stable(exc_addr_q)));

    // R12
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_req && !ret_req) |=> ($stable(next_pc_q) && $stable(exc_addr_q) && !valid_q));
endmodule

// File: rtl/priv_call_unit.sv
module priv_call_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic [7:0]        call_code,
    input  logic [ADDR_W-1:0] call_pc,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pc_valid,
    output logic [ADDR_W-1:0] exc_addr,
    output logic              priv_mode,
    output logic              swap_req,
    output logic              flush
);
    logic [OFS_W-1:0]  entry_ofs;
    logic [ADDR_W-1:0] base_q;

    pcu_vector u_vector (
        .code      (call_code),
        .entry_ofs (entry_ofs)
    );

    pcu_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_we),
        .wr_data (base_wdata),
        .base_q  (base_q),
        .flush_q (flush)
    );

    pcu_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_req (call_req),
        .ret_req  (ret_req),
        .ret_mode (ret_addr[0]),
        .mode_o   (priv_mode),
        .swap_q   (swap_req)
    );

    pcu_pc_path #(.ADDR_W(ADDR_W)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .call_req   (call_req),
        .ret_req    (ret_req),
        .call_pc    (call_pc),
        .ret_addr   (ret_addr),
        .base_q     (base_q),
        .entry_ofs  (entry_ofs),
        .mode_now   (priv_mode),
        .next_pc_q  (next_pc),
        .exc_addr_q (exc_addr),
        .valid_q    (pc_valid)
    );

    // R10
    call_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && ret_req) |=> (priv_mode && (exc_addr == ($past(call_pc) | ADDR_W'($past(priv_mode))))));

    // R9
    ret_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req) |=> (swap_req == ($past(priv_mode) != $past(ret_addr[0]))));
endmodule

// File: tb/priv_call_unit_bench.sv
module priv_call_unit_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_req = 1'b0;
    logic [7:0]    call_code = '0;
    logic [AW-1:0] call_pc = '0;
    logic          ret_req = 1'b0;
    logic [AW-1:0] ret_addr = '0;
    logic          base_we = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic [AW-1:0] next_pc;
    logic          pc_valid;
    logic [AW-1:0] exc_addr;
    logic          priv_mode;
    logic          swap_req;
    logic          flush;

    int n_cmp = 0;
    int n_bad = 0;
    logic          m_mode;
    logic [AW-1:0] m_base;
    logic [AW-1:0] m_next;
    logic [AW-1:0] m_exc;

    always #5 clk = ~clk;

    priv_call_unit #(.ADDR_W(AW)) u_priv_call_unit (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_code(call_code),
        .call_pc(call_pc), .ret_req(ret_req), .ret_addr(ret_addr),
        .base_we(base_we), .base_wdata(base_wdata), .next_pc(next_pc),
        .pc_valid(pc_valid), .exc_addr(exc_addr), .priv_mode(priv_mode),
        .swap_req(swap_req), .flush(flush)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [AW-1:0] exp_ofs(input logic [7:0] c);
        logic [7:0] m;
        m = c[7] ? (c & 8'hBF) : (c & 8'h3F);
        if (m[7]) exp_ofs = 32'h2000 + (32'(m) - 32'h80) * 64;
        else      exp_ofs = 32'h1000 + 32'(m) * 64;
    endfunction

    task automatic check_idle();
        @(negedge clk);
        chk("R12 swap pulse", 64'(swap_req), 64'(0));
        chk("R12 valid pulse", 64'(pc_valid), 64'(0));
        chk("R12 flush pulse", 64'(flush), 64'(0));
        chk("R12 next_pc hold", 64'(next_pc), 64'(m_next));
        chk("R12 exc hold", 64'(exc_addr), 64'(m_exc));
        chk("R12 mode hold", 64'(priv_mode), 64'(m_mode));
    endtask

    task automatic do_call(input logic [7:0] code, input logic [AW-1:0] pc, input bit idle_chk);
        string tag;
        logic  exp_swap;
        tag = code[6] ? "R1" : (code[7] ? "R2" : "R3");
        @(negedge clk);
        call_req = 1'b1; call_code = code; call_pc = pc;
        @(negedge clk);
        call_req = 1'b0;
        m_next   = m_base + exp_ofs(code);
        m_exc    = pc | AW'(m_mode);
        exp_swap = !m_mode;
        m_mode   = 1'b1;
        chk({tag, " R4 next_pc"}, 64'(next_pc), 64'(m_next));
        chk("R4 pc_valid", 64'(pc_valid), 64'(1));
        chk("R5 exc_addr", 64'(exc_addr), 64'(m_exc));
        chk("R6 mode", 64'(priv_mode), 64'(1));
        chk("R6 swap", 64'(swap_req), 64'(exp_swap));
        if (idle_chk) check_idle();
    endtask

    task automatic do_ret(input logic [AW-1:0] addr);
        logic exp_swap;
        @(negedge clk);
        ret_req = 1'b1; ret_addr = addr;
        @(negedge clk);
        ret_req  = 1'b0;
        exp_swap = (m_mode != addr[0]);
        m_mode   = addr[0];
        m_next   = addr & ~AW'(1);
        chk("R8 next_pc", 64'(next_pc), 64'(m_next));
        chk("R8 mode", 64'(priv_mode), 64'(m_mode));
        chk("R8 exc unchanged", 64'(exc_addr), 64'(m_exc));
        chk("R8 pc_valid", 64'(pc_valid), 64'(1));
        chk("R9 swap", 64'(swap_req), 64'(exp_swap));
    endtask

    task automatic do_base(input logic [AW-1:0] val);
        @(negedge clk);
        base_we = 1'b1; base_wdata = val;
        @(negedge clk);
        base_we = 1'b0;
        m_base  = val;
        chk("R7 flush", 64'(flush), 64'(1));
        check_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        m_mode = 1'b1; m_base = '0; m_next = '0; m_exc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 next_pc", 64'(next_pc), 64'(0));
        chk("R11 exc_addr", 64'(exc_addr), 64'(0));
        chk("R11 mode", 64'(priv_mode), 64'(1));
        chk("R11 swap", 64'(swap_req), 64'(0));
        chk("R11 flush", 64'(flush), 64'(0));
        chk("R11 valid", 64'(pc_valid), 64'(0));
        // R11 base is 0: first call lands on the low-range origin
        do_call(8'h00, 32'h0000_0100, 1'b1);

        // R1 R2 R3 R6 R9: full code sweep from both modes, several bases
        for (int b = 0; b < 8; b++) begin
            do_base(b == 7 ? 32'hFFFF_E000 : 32'(b) * 32'h1357_9BC0);
            for (int c = b * 32; c < b * 32 + 32; c++) begin
                for (int m = 0; m < 2; m++) begin
                    do_ret(32'h0800_0000 + 32'(c) * 16 + 32'(m));
                    do_call(8'(c), 32'h4000_0000 | (32'(c) << 8) | 32'(c & 1), (c % 8) == 0);
                end
            end
        end

        // R7 call and base write together: old base used, new base after
        @(negedge clk);
        call_req = 1'b1; call_code = 8'h85; call_pc = 32'h0000_2220;
        base_we = 1'b1; base_wdata = 32'h0050_0000;
        @(negedge clk);
        call_req = 1'b0; base_we = 1'b0;
        m_next = m_base + exp_ofs(8'h85);
        m_exc  = 32'h0000_2220 | AW'(m_mode);
        m_mode = 1'b1;
        chk("R7 old base used", 64'(next_pc), 64'(m_next));
        chk("R7 flush with call", 64'(flush), 64'(1));
        m_base = 32'h0050_0000;
        do_call(8'h85, 32'h0000_3330, 1'b1);
        chk("R7 new base used", 64'(next_pc), 64'(32'h0050_0000 + 32'h2140));

        // R10 call and return together from normal mode
        do_ret(32'h0000_7770);
        @(negedge clk);
        call_req = 1'b1; call_code = 8'h83; call_pc = 32'h0000_4440;
        ret_req = 1'b1; ret_addr = 32'h0000_5554;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0;
        m_next = m_base + exp_ofs(8'h83);
        m_exc  = 32'h0000_4440;
        m_mode = 1'b1;
        chk("R10 next_pc", 64'(next_pc), 64'(m_next));
        chk("R10 exc_addr", 64'(exc_addr), 64'(m_exc));
        chk("R10 mode", 64'(priv_mode), 64'(1));
        chk("R10 swap", 64'(swap_req), 64'(1));
        check_idle();

        // R9 return privileged to privileged: no swap
        do_ret(32'h0000_9991);
        check_idle();

        summary();
        $finish;
    end
endmodule